// File: doc/BRIEF.md
# Command-Stream Arithmetic Coprocessor

This block executes short arithmetic programs embedded in a 32-bit command stream. A header word opens a math packet and states how many instruction words follow. Each of those words runs in the cycle it is accepted. An instruction either copies a value into one of two 64-bit source latches (A and B), combines the latches into a 64-bit accumulator with zero and carry flags, or writes a value back into one of sixteen 64-bit general purpose registers. The accumulator and both flags can also be named as source operands, and copy operations may invert the value on the way.

A host port gives word-wide access to the general purpose registers, with each 64-bit register split into a low and a high 32-bit half. The host uses this port to seed operands before a packet runs and to collect results afterwards. Words outside a packet belong to other command types and are dropped. Faulty instruction words raise a one-cycle error strobe.

Top module: `cs_math_unit`

## Requirements
- R1: `cmd_ready_o` is always high. While idle, a word with value 0x1A in bits 28:23 is a header, and bits 7:0 hold the count of following instruction words minus one. Exactly that many words then execute, and the unit returns to idle. Any other word received while idle has no effect.
- R2: An instruction word has its opcode in bits 31:20, its first operand (destination) in bits 19:10 and its second operand (source) in bits 9:0. Opcode 0x080 copies the source into the latch named by the destination (0x20 = A, 0x21 = B). Opcode 0x480 copies the bitwise inverse.
- R3: Opcode 0x081 clears the named latch. Opcode 0x481 sets every bit of it. The source field is ignored.
- R4: Opcode 0x100 puts A+B in the accumulator and the carry-out in the carry flag. Opcode 0x101 puts A−B there, with the borrow (A<B unsigned) in the carry flag. In both cases the zero flag is set exactly when the 64-bit result is zero.
- R5: Opcodes 0x102, 0x103 and 0x104 put A AND B, A OR B and A XOR B in the accumulator, set the zero flag from the result, and clear the carry flag.
- R6: Opcode 0x180 copies the source into the general purpose register named by the destination (0x00–0x0F). Opcode 0x580 copies the inverse.
- R7: Source codes 0x00–0x0F read the general purpose registers, 0x20/0x21 read the latches and 0x31 reads the accumulator. Codes 0x32 and 0x33 read the zero and carry flags as a 64-bit 0 or 1.
- R8: Opcode 0x000 changes nothing.
- R9: An unknown opcode, or an operand code that is illegal for its position, changes nothing and sets `err_o` for exactly the cycle after the word is accepted.
- R10: Host byte address 0x600 + 8·n holds the low half of register n, and address +4 holds the high half. Writes update only that half. Reads are combinational, and other addresses read as 0 and ignore writes.
- R11: When an instruction store and a host write target the same register in the same cycle, the register takes the instruction's value.
- R12: After reset all registers, latches, the accumulator and the flags are zero, `err_o` is low and the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Command word accepted (always high) |
| cmd_data_i | input | 32 | Command word |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 12 | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data |
| acc_o | output | 64 | Accumulator |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry / borrow flag |
| err_o | output | 1 | One-cycle error strobe |

## Verification
The adder is driven with all-ones plus one, which sets zero and carry together. The subtractor is driven with a smaller minus a larger operand and then the reverse, which separates borrow from carry-out. The logic operations use overlapping nibble patterns, so each of AND, OR and XOR gives a distinct result, and one of them follows a borrow to show the carry being cleared. Inverted copies, the constant loads, flag reads and a packet that is one word shorter than the words sent separate the copy variants from one another and check the length count against its off-by-one.

// File: rtl/cs_math_pkg.sv
package cs_math_pkg;
  localparam int unsigned DATA_W  = 64;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OPD_W   = 10;
  localparam int unsigned OPC_W   = 12;
  localparam int unsigned NUM_GPR = 16;
  localparam int unsigned LEN_W   = 8;

  localparam logic [5:0] HDR_CMD = 6'h1A;

  localparam logic [OPC_W-1:0] OPC_NOP     = 12'h000;
  localparam logic [OPC_W-1:0] OPC_LOAD    = 12'h080;
  localparam logic [OPC_W-1:0] OPC_LOADINV = 12'h480;
  localparam logic [OPC_W-1:0] OPC_LOAD0   = 12'h081;
  localparam logic [OPC_W-1:0] OPC_LOAD1   = 12'h481;
  localparam logic [OPC_W-1:0] OPC_ADD     = 12'h100;
  localparam logic [OPC_W-1:0] OPC_SUB     = 12'h101;
  localparam logic [OPC_W-1:0] OPC_AND     = 12'h102;
  localparam logic [OPC_W-1:0] OPC_OR      = 12'h103;
  localparam logic [OPC_W-1:0] OPC_XOR     = 12'h104;
  localparam logic [OPC_W-1:0] OPC_STORE   = 12'h180;
  localparam logic [OPC_W-1:0] OPC_STOREINV= 12'h580;

  localparam logic [OPD_W-1:0] OPD_SRCA  = 10'h020;
  localparam logic [OPD_W-1:0] OPD_SRCB  = 10'h021;
  localparam logic [OPD_W-1:0] OPD_ACC   = 10'h031;
  localparam logic [OPD_W-1:0] OPD_ZF    = 10'h032;
  localparam logic [OPD_W-1:0] OPD_CF    = 10'h033;

  typedef enum logic [3:0] {
    K_NOP, K_LOAD, K_LOADC, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_STORE
  } kind_e;

  typedef struct packed {
    kind_e            kind;
    logic             inv;
    logic [OPD_W-1:0] dst;
    logic [OPD_W-1:0] src;
  } op_t;

  function automatic logic is_gpr(input logic [OPD_W-1:0] c);
    return c < OPD_W'(NUM_GPR);
  endfunction

  function automatic logic is_latch(input logic [OPD_W-1:0] c);
    return (c == OPD_SRCA) || (c == OPD_SRCB);
  endfunction

  function automatic logic is_readable(input logic [OPD_W-1:0] c);
    return is_gpr(c) || is_latch(c) || (c == OPD_ACC) || (c == OPD_ZF) || (c == OPD_CF);
  endfunction
endpackage

// File: rtl/cs_math_decode.sv
module cs_math_decode
  import cs_math_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              exec_o,
  output op_t               op_o,
  output logic              err_o
);
  logic             busy_q;
  logic [LEN_W:0]   remain_q;
  logic             is_hdr, bad;
  logic [OPC_W-1:0] opc;
  logic [OPD_W-1:0] opa, opb;

  assign opc    = word_i[31:20];
  assign opa    = word_i[19:10];
  assign opb    = word_i[9:0];
  assign is_hdr = valid_i && !busy_q && (word_i[28:23] == HDR_CMD);
  assign exec_o = valid_i && busy_q;

  always_comb begin
    op_o = '{kind: K_NOP, inv: 1'b0, dst: opa, src: opb};
    bad  = 1'b0;
    unique case (opc)
      OPC_NOP: ;
      OPC_LOAD, OPC_LOADINV: begin
        op_o.kind = K_LOAD;
        op_o.inv  = opc[10];
        bad       = !(is_latch(opa) && is_readable(opb));
      end
      OPC_LOAD0, OPC_LOAD1: begin
        op_o.kind = K_LOADC;
        op_o.inv  = opc[10];
        bad       = !is_latch(opa);
      end
      OPC_ADD: op_o.kind = K_ADD;
      OPC_SUB: op_o.kind = K_SUB;
      OPC_AND: op_o.kind = K_AND;
      OPC_OR:  op_o.kind = K_OR;
      OPC_XOR: op_o.kind = K_XOR;
      OPC_STORE, OPC_STOREINV: begin
        op_o.kind = K_STORE;
        op_o.inv  = opc[10];
        bad       = !(is_gpr(opa) && is_readable(opb));
      end
      default: bad = 1'b1;
    endcase
    if (bad) op_o.kind = K_NOP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      remain_q <= '0;
      err_o    <= 1'b0;
    end else begin
      err_o <= exec_o && bad;
      if (is_hdr) begin
        busy_q   <= 1'b1;
        remain_q <= {1'b0, word_i[LEN_W-1:0]} + 1'b1;
      end else if (exec_o) begin
        if (remain_q == 1) busy_q <= 1'b0;
        remain_q <= remain_q - 1'b1;
      end
    end
  end

  AST_PKT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_o && remain_q == 1) |=> !busy_q); // R1
  AST_ERR_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(valid_i && busy_q)); // R9
endmodule

// File: rtl/cs_math_alu.sv
module cs_math_alu
  import cs_math_pkg::*;
(
  input  kind_e             kind_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              arith_o,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic [DATA_W:0] sum, dif;
  assign sum = {1'b0, a_i} + {1'b0, b_i};
  assign dif = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    arith_o = 1'b1;
    carry_o = 1'b0;
    res_o   = '0;
    unique case (kind_i)
      K_ADD: {carry_o, res_o} = sum;
      K_SUB: {carry_o, res_o} = dif;
      K_AND: res_o = a_i & b_i;
      K_OR:  res_o = a_i | b_i;
      K_XOR: res_o = a_i ^ b_i;
      default: arith_o = 1'b0;
    endcase
    zero_o = (res_o == '0);
  end
endmodule

// File: rtl/cs_math_gpr.sv
module cs_math_gpr
  import cs_math_pkg::*;
#(
  parameter int unsigned N_REG  = NUM_GPR,
  parameter int unsigned ADDR_W = 12,
  parameter logic [11:0] BASE   = 12'h600,
  localparam int unsigned IDX_W = $clog2(N_REG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        host_we_i,
  input  logic [ADDR_W-1:0]           host_addr_i,
  input  logic [WORD_W-1:0]           host_wdata_i,
  output logic [WORD_W-1:0]           host_rdata_o,
  input  logic                        inst_we_i,
  input  logic [IDX_W-1:0]            inst_idx_i,
  input  logic [DATA_W-1:0]           inst_wdata_i,
  output logic [N_REG-1:0][DATA_W-1:0] regs_o
);
  logic [ADDR_W-1:0] off;
  logic              hit, hi;
  logic [IDX_W-1:0]  hidx;

  assign off  = host_addr_i - ADDR_W'(BASE);
  assign hit  = (host_addr_i >= ADDR_W'(BASE)) && (off < ADDR_W'(N_REG * 8)) && (off[1:0] == 2'b00);
  assign hi   = off[2];
  assign hidx = off[IDX_W+2:3];
  assign host_rdata_o = !hit ? '0 : (hi ? regs_o[hidx][63:32] : regs_o[hidx][31:0]);

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[g] <= '0;
      else if (inst_we_i && inst_idx_i == IDX_W'(g)) regs_o[g] <= inst_wdata_i;
      else if (host_we_i && hit && hidx == IDX_W'(g)) begin
        if (hi) regs_o[g][63:32] <= host_wdata_i;
        else    regs_o[g][31:0]  <= host_wdata_i;
      end
    end
  end

  AST_INST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inst_we_i && host_we_i && hit && hidx == inst_idx_i)
    |=> regs_o[$past(inst_idx_i)] == $past(inst_wdata_i)); // R11
  AST_HOST_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && hit && !hi && !(inst_we_i && inst_idx_i == hidx))
    |=> regs_o[$past(hidx)][31:0] == $past(host_wdata_i)); // R10
endmodule

// File: rtl/cs_math_unit.sv
module cs_math_unit
  import cs_math_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [31:0]       cmd_data_i,
  input  logic              host_we_i,
  input  logic [11:0]       host_addr_i,
  input  logic [31:0]       host_wdata_i,
  output logic [31:0]       host_rdata_o,
  output logic [63:0]       acc_o,
  output logic              zero_o,
  output logic              carry_o
  ,output logic             err_o
);
  localparam int unsigned IDX_W = $clog2(NUM_GPR);

  logic                            exec;
  op_t                             op;
  logic [NUM_GPR-1:0][DATA_W-1:0]  regs;
  logic [DATA_W-1:0]               srca_q, srcb_q, acc_q, src_val, mv_val, alu_res;
  logic                            zf_q, cf_q, alu_arith, alu_c, alu_z;

  assign cmd_ready_o = 1'b1;

  cs_math_decode u_dec (
    .clk_i, .rst_ni, .valid_i(cmd_valid_i), .word_i(cmd_data_i),
    .exec_o(exec), .op_o(op), .err_o(err_o)
  );

  always_comb begin
    src_val = '0;
    if (is_gpr(op.src))         src_val = regs[op.src[IDX_W-1:0]];
    else if (op.src == OPD_SRCA) src_val = srca_q;
    else if (op.src == OPD_SRCB) src_val = srcb_q;
    else if (op.src == OPD_ACC)  src_val = acc_q;
    else if (op.src == OPD_ZF)   src_val = DATA_W'(zf_q);
    else if (op.src == OPD_CF)   src_val = DATA_W'(cf_q);
    if (op.kind == K_LOADC) mv_val = op.inv ? '1 : '0;
    else                    mv_val = op.inv ? ~src_val : src_val;
  end

  cs_math_alu u_alu (
    .kind_i(op.kind), .a_i(srca_q), .b_i(srcb_q),
    .arith_o(alu_arith), .res_o(alu_res), .carry_o(alu_c), .zero_o(alu_z)
  );

  cs_math_gpr u_gpr (
    .clk_i, .rst_ni, .host_we_i, .host_addr_i, .host_wdata_i, .host_rdata_o,
    .inst_we_i(exec && op.kind == K_STORE), .inst_idx_i(op.dst[IDX_W-1:0]),
    .inst_wdata_i(mv_val), .regs_o(regs)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srca_q <= '0;
      srcb_q <= '0;
      acc_q  <= '0;
      zf_q   <= 1'b0;
      cf_q   <= 1'b0;
    end else if (exec) begin
      if (op.kind == K_LOAD || op.kind == K_LOADC) begin
        if (op.dst == OPD_SRCA) srca_q <= mv_val;
        else                    srcb_q <= mv_val;
      end
      if (alu_arith) begin
        acc_q <= alu_res;
        zf_q  <= alu_z;
        cf_q  <= alu_c;
      end
    end
  end

  assign acc_o   = acc_q;
  assign zero_o  = zf_q;
  assign carry_o = cf_q;

  AST_ZF_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && alu_arith) |=> zf_q == (acc_q == '0)); // R4
  AST_LOGIC_NC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && (op.kind == K_AND || op.kind == K_OR || op.kind == K_XOR)) |=> !cf_q); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec |=> $stable(srca_q) && $stable(srcb_q) && $stable(acc_q)); // R1
endmodule

// File: tb/cs_math_unit_bench.sv
module cs_math_unit_bench;
  localparam time CLK_T = 10ns;

  logic        clk = 0, rst_n = 0;
  logic        cmd_valid = 0, cmd_ready;
  logic [31:0] cmd_data = 0;
  logic        host_we = 0;
  logic [11:0] host_addr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [63:0] acc;
  logic        zf, cf, err;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_T/2) clk = ~clk;

  cs_math_unit u_cs_math_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_data_i(cmd_data), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .acc_o(acc),
    .zero_o(zf), .carry_o(cf), .err_o(err)
  );

  function automatic logic [31:0] ins(input logic [11:0] o, input logic [9:0] a, input logic [9:0] b);
    return {o, a, b};
  endfunction
  function automatic logic [31:0] hdr(input int n);
    return (32'h1A << 23) | 32'(n - 1);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    @(negedge clk); cmd_valid = 1; cmd_data = w;
    @(negedge clk); cmd_valid = 0; cmd_data = 0;
  endtask

  task automatic hwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask

  task automatic wr64(input int n, input logic [63:0] v);
    hwr(12'(12'h600 + 8*n), v[31:0]);
    hwr(12'(12'h604 + 8*n), v[63:32]);
  endtask

  task automatic rd64(input int n, output logic [63:0] v);
    host_addr = 12'(12'h600 + 8*n); #1; v[31:0] = host_rdata;
    host_addr = 12'(12'h604 + 8*n); #1; v[63:32] = host_rdata;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd64(0, v);  chk("R12 gpr0", v, 0);
    rd64(15, v); chk("R12 gpr15", v, 0);
    chk("R12 acc/flags/err", {acc, zf, cf, err}, 0);
    chk("R1 ready", cmd_ready, 1);
  endtask

  task automatic t_host;
    logic [63:0] v;
    wr64(3, 64'h1234_5678_9ABC_DEF0);
    rd64(3, v); chk("R10 rw halves", v, 64'h1234_5678_9ABC_DEF0);
    hwr(12'h604 + 12'd24, 32'hCAFE_F00D);
    rd64(3, v); chk("R10 high half only", v, 64'hCAFE_F00D_9ABC_DEF0);
    hwr(12'h5F8, 32'hFFFF_FFFF);
    host_addr = 12'h5F8; #1; chk("R10 unmapped read", host_rdata, 0);
    rd64(15, v); chk("R10 unmapped write", v, 0);
  endtask

  task automatic t_load_store;
    logic [63:0] v;
    put(hdr(4));
    put(ins(12'h080, 10'h20, 10'h03));
    put(ins(12'h480, 10'h21, 10'h03));
    put(ins(12'h180, 10'h04, 10'h20));
    put(ins(12'h580, 10'h05, 10'h21));
    rd64(4, v); chk("R2/R6 load+store", v, 64'hCAFE_F00D_9ABC_DEF0);
    rd64(5, v); chk("R2/R6 inv+inv", v, 64'hCAFE_F00D_9ABC_DEF0);
    put(hdr(1)); put(ins(12'h180, 10'h06, 10'h21));
    rd64(6, v); chk("R2 loadinv", v, ~64'hCAFE_F00D_9ABC_DEF0);
  endtask

  task automatic t_add;
    logic [63:0] v;
    wr64(1, '1); wr64(2, 64'd1);
    put(hdr(6));
    put(ins(12'h080, 10'h20, 10'h01));
    put(ins(12'h080, 10'h21, 10'h02));
    put(ins(12'h100, 0, 0));
    put(ins(12'h180, 10'h06, 10'h31));
    put(ins(12'h180, 10'h07, 10'h32));
    put(ins(12'h180, 10'h08, 10'h33));
    chk("R4 add acc", acc, 0);
    chk("R4 add zf/cf", {zf, cf}, 2'b11);
    rd64(6, v); chk("R7 acc read", v, 0);
    rd64(7, v); chk("R7 zf read", v, 1);
    rd64(8, v); chk("R7 cf read", v, 1);
  endtask

  task automatic t_sub;
    wr64(1, 64'd5); wr64(2, 64'd7);
    put(hdr(3));
    put(ins(12'h080, 10'h20, 10'h01));
    put(ins(12'h080, 10'h21, 10'h02));
    put(ins(12'h101, 0, 0));
    chk("R4 sub small-large", {acc, zf, cf}, {64'hFFFF_FFFF_FFFF_FFFE, 2'b01});
    put(hdr(3));
    put(ins(12'h080, 10'h21, 10'h01));
    put(ins(12'h080, 10'h20, 10'h02));
    put(ins(12'h101, 0, 0));
    chk("R4 sub large-small", {acc, zf, cf}, {64'd2, 2'b00});
  endtask

  task automatic t_logic;
    logic [63:0] a = 64'hF0F0_0000_FFFF_0000, b = 64'hFF00_FF00_0F0F_00FF;
    wr64(1, a); wr64(2, b);
    put(hdr(5));
    put(ins(12'h081, 10'h20, 0));
    put(ins(12'h481, 10'h21, 0));
    put(ins(12'h101, 0, 0));
    put(ins(12'h080, 10'h20, 10'h01));
    put(ins(12'h080, 10'h21, 10'h02));
    chk("R3 load0-load1 borrow", cf, 1);
    put(hdr(1)); put(ins(12'h102, 0, 0));
    chk("R5 and", {acc, zf, cf}, {a & b, 2'b00});
    put(hdr(1)); put(ins(12'h103, 0, 0));
    chk("R5 or", acc, a | b);
    put(hdr(1)); put(ins(12'h104, 0, 0));
    chk("R5 xor", acc, a ^ b);
    put(hdr(3));
    put(ins(12'h481, 10'h20, 10'h3FF));
    put(ins(12'h081, 10'h21, 10'h3FF));
    put(ins(12'h100, 0, 0));
    chk("R3 ones+zero", {acc, zf, cf}, {64'hFFFF_FFFF_FFFF_FFFF, 2'b00});
  endtask

  task automatic t_noop_err;
    logic [63:0] v, a0;
    a0 = acc;
    put(hdr(1)); put(ins(12'h000, 10'h05, 10'h06));
    chk("R8 noop acc", acc, a0);
    chk("R8 noop err", err, 0);
    put(hdr(3));
    @(negedge clk); cmd_valid = 1; cmd_data = ins(12'h200, 10'h20, 10'h01);
    @(negedge clk); cmd_valid = 0;
    chk("R9 unknown opcode err", err, 1);
    @(negedge clk); chk("R9 err one cycle", err, 0);
    put(ins(12'h080, 10'h20, 10'h25));
    chk("R9 bad src err", err, 1);
    put(ins(12'h180, 10'h20, 10'h01));
    chk("R9 bad dst err", err, 1);
    put(hdr(1)); put(ins(12'h180, 10'h09, 10'h20));
    rd64(9, v); chk("R9 latch unchanged", v, '1);
  endtask

  task automatic t_packet;
    logic [63:0] v;
    wr64(10, 64'h55);
    put(ins(12'h180, 10'h0A, 10'h31));
    rd64(10, v); chk("R1 idle word dropped", v, 64'h55);
    put(hdr(1));
    put(ins(12'h180, 10'h0B, 10'h31));
    put(ins(12'h180, 10'h0A, 10'h31));
    rd64(11, v); chk("R1 last word runs", v, acc);
    rd64(10, v); chk("R1 extra word dropped", v, 64'h55);
  endtask

  task automatic t_collide;
    logic [63:0] v;
    put(hdr(1));
    @(negedge clk);
    cmd_valid = 1; cmd_data = ins(12'h180, 10'h0C, 10'h31);
    host_we = 1; host_addr = 12'h600 + 12'd96; host_wdata = 32'hDEAD_BEEF;
    @(negedge clk); cmd_valid = 0; host_we = 0;
    rd64(12, v); chk("R11 instruction wins", v, acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_host;
    t_load_store;
    t_add;
    t_sub;
    t_logic;
    t_noop_err;
    t_packet;
    t_collide;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule